// File: doc/BRIEF.md
# Cascaded Interrupt Multiplexer

This block gathers sixteen interrupt request lines from board-level logic and presents them to a host processor as one level-sensitive interrupt line. Each source has three state bits. A pending bit latches the source while the source is enabled. An enable bit decides whether the source may latch at all. An unmask bit decides whether a pending bit may reach the combined output.

The host reaches the block through a small 16-bit register port. The port has a read strobe, a write strobe, a byte address and write data. Registers sit four bytes apart. The enable and unmask bits are changed only through dedicated set and clear registers. In those registers a 1 in the written word acts on that source and a 0 leaves it alone, so the host never has to read, modify and write back.

Pending bits are acknowledged by writing ones to the pending register. Sources are treated as levels: a source that is still high after it has been acknowledged latches again at once. Source lines are expected to be synchronous to the block clock.

Top module: `irqmux_cascade`

## Requirements
- R1: While reset is active and after it is released, all pending bits are 0, all enable bits are 0, all sources are masked (unmask bits 0), `irq_o` is 0 and `bus_rdata_o` is 0.
- R2: The register index is `bus_addr_i[4:2]`, and `bus_addr_i[1:0]` is ignored. The indices are: 0 pending/acknowledge, 1 enable-set, 2 enable-clear, 3 unmask-set, 4 mask (unmask-clear). Indices 5 to 7 read as 0, and writes to them change nothing.
- R3: A write to enable-set sets every enable bit whose data bit is 1. A write to enable-clear clears every enable bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R4: A write to unmask-set unmasks every source whose data bit is 1. A write to the mask register masks every source whose data bit is 1. Bits whose data bit is 0 keep their value.
- R5: On each clock edge where source n is high and its enable bit is 1, pending bit n becomes 1. A disabled source never sets its pending bit. Masking does not stop a source from latching.
- R6: Writing index 0 clears every pending bit whose data bit is 1, and data bits of 0 have no effect. If a source is high and enabled on the same edge as its acknowledge, its pending bit stays 1.
- R7: `irq_o` is a register that is 1 exactly when some source has pending, enable and unmask all at 1 in the state the same clock edge produces. It therefore changes on the edge that captures the write or the source change.
- R8: A read strobe on one edge loads `bus_rdata_o` with the selected register as it stood before that edge. Index 0 returns the pending bits, indices 1 and 2 return the enable bits, and indices 3 and 4 return the unmask bits, with bit n belonging to source n. Without a read strobe, `bus_rdata_o` holds its value.
- R9: The start-up sequence is 0xFFFF written to the mask register, then 0xFFFF to enable-set, then 0xFFFF to index 0. With all sources low, it leaves every source masked and enabled, no bit pending and `irq_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| arst_ni | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| src_i | input | 16 | Interrupt source levels, synchronous to clk_i |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_addr_i | input | 5 | Byte address; bits [4:2] select the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Combined level interrupt to the host |

## Verification
The assertions take four things for granted about the inputs:
- the read and write strobes are never high in the same cycle;
- each write selects exactly one register, so an enable-set and an enable-clear never land on the same edge;
- source lines change only just after a clock edge;
- nothing is driven until the internal reset has been released.

The stimulus keeps within these limits. It drives every input a fixed time after the rising edge, and it issues at most one bus access per cycle. Both the directed phase and the pseudo-random phase choose between a read, a write or an idle cycle, never a read and a write together.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;

  localparam int unsigned REG_IX_W = 3;

  typedef enum logic [REG_IX_W-1:0] {
    RIX_PEND    = 3'd0,
    RIX_EN_SET  = 3'd1,
    RIX_EN_CLR  = 3'd2,
    RIX_UNM_SET = 3'd3,
    RIX_UNM_CLR = 3'd4
  } reg_ix_e;

  typedef struct packed {
    logic ack;
    logic en_set;
    logic en_clr;
    logic unm_set;
    logic unm_clr;
  } wr_sel_t;

endpackage

// File: rtl/irqmux_rst_sync.sv
module irqmux_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/irqmux_decode.sv
module irqmux_decode
  import irqmux_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output wr_sel_t             wsel_o,
  output logic [ADDR_W-3:0]   rix_o
);

  localparam int unsigned IX_W = ADDR_W - 2;

  logic [IX_W-1:0] ix;
  logic            unused_lo;

  assign ix        = addr_i[ADDR_W-1:2];
  assign unused_lo = ^addr_i[1:0];
  assign rix_o     = ix;

  always_comb begin
    wsel_o         = '0;
    wsel_o.ack     = wr_i && (ix == IX_W'(RIX_PEND));
    wsel_o.en_set  = wr_i && (ix == IX_W'(RIX_EN_SET));
    wsel_o.en_clr  = wr_i && (ix == IX_W'(RIX_EN_CLR));
    wsel_o.unm_set = wr_i && (ix == IX_W'(RIX_UNM_SET));
    wsel_o.unm_clr = wr_i && (ix == IX_W'(RIX_UNM_CLR));
  end

  // R2
  wsel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wsel_o));

  // R2
  unused_ix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ix > IX_W'(RIX_UNM_CLR)) |-> (wsel_o == '0));

endmodule

// File: rtl/irqmux_cell.sv
module irqmux_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic wbit_i,
  input  logic ack_we_i,
  input  logic ens_we_i,
  input  logic enc_we_i,
  input  logic unms_we_i,
  input  logic unmc_we_i,
  output logic pend_q_o,
  output logic en_q_o,
  output logic unm_q_o,
  output logic pend_d_o,
  output logic en_d_o,
  output logic unm_d_o
);

  logic pend_q, en_q, unm_q;
  logic pend_d, en_d, unm_d;
  logic pend_ce, en_ce, unm_ce;
  logic latch_hit;

  always_comb begin
    latch_hit = src_i & en_q;
    pend_ce   = latch_hit | (ack_we_i & wbit_i);
    en_ce     = (ens_we_i | enc_we_i) & wbit_i;
    unm_ce    = (unms_we_i | unmc_we_i) & wbit_i;
    pend_d    = pend_q;
    en_d      = en_q;
    unm_d     = unm_q;
    if (pend_ce) pend_d = latch_hit;
    if (en_ce)   en_d   = ens_we_i;
    if (unm_ce)  unm_d  = unms_we_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      unm_q  <= 1'b0;
    end else begin
      if (pend_ce) pend_q <= pend_d;
      if (en_ce)   en_q   <= en_d;
      if (unm_ce)  unm_q  <= unm_d;
    end
  end

  assign pend_q_o = pend_q;
  assign en_q_o   = en_q;
  assign unm_q_o  = unm_q;
  assign pend_d_o = pend_d;
  assign en_d_o   = en_d;
  assign unm_d_o  = unm_d;

  // R5
  latch_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i && en_q) |=> pend_q);

  // R5
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !pend_q) |=> !pend_q);

  // R6
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && wbit_i && !(src_i && en_q)) |=> !pend_q);

  // R6
  ack_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && !wbit_i && pend_q) |=> pend_q);

  // R3
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ens_we_i && wbit_i) |=> en_q);

  // R3
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_we_i && wbit_i) |=> !en_q);

  // R4
  unm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unms_we_i && wbit_i) |=> unm_q);

  // R4
  unm_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unmc_we_i && wbit_i) |=> !unm_q);

  // R4
  unm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((unms_we_i || unmc_we_i) && wbit_i) |=> $stable(unm_q));

endmodule

// File: rtl/irqmux_combine.sv
module irqmux_combine #(
  parameter int unsigned NSRC = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] pend_d_i,
  input  logic [NSRC-1:0] en_d_i,
  input  logic [NSRC-1:0] unm_d_i,
  input  logic [NSRC-1:0] pend_q_i,
  input  logic [NSRC-1:0] en_q_i,
  input  logic [NSRC-1:0] unm_q_i,
  output logic            irq_o
);

  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = |(pend_d_i & en_d_i & unm_d_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R7
  irq_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q == (|(pend_q_i & en_q_i & unm_q_i)));

endmodule

// File: rtl/irqmux_cascade.sv
module irqmux_cascade
  import irqmux_pkg::*;
#(
  parameter int unsigned NSRC       = 16,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  localparam int unsigned IX_W = ADDR_W - 2;

  logic              rst_n;
  wr_sel_t           wsel;
  logic [IX_W-1:0]   rix;
  logic [NSRC-1:0]   pend_q, en_q, unm_q;
  logic [NSRC-1:0]   pend_d, en_d, unm_d;
  logic [DATA_W-1:0] rdata_q, rdata_d, rsel;

  irqmux_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .rst_no (rst_n)
  );

  irqmux_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .wr_i  (bus_wr_i),
    .addr_i(bus_addr_i),
    .wsel_o(wsel),
    .rix_o (rix)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_cell
    irqmux_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_n),
      .src_i    (src_i[g]),
      .wbit_i   (bus_wdata_i[g]),
      .ack_we_i (wsel.ack),
      .ens_we_i (wsel.en_set),
      .enc_we_i (wsel.en_clr),
      .unms_we_i(wsel.unm_set),
      .unmc_we_i(wsel.unm_clr),
      .pend_q_o (pend_q[g]),
      .en_q_o   (en_q[g]),
      .unm_q_o  (unm_q[g]),
      .pend_d_o (pend_d[g]),
      .en_d_o   (en_d[g]),
      .unm_d_o  (unm_d[g])
    );
  end

  irqmux_combine #(.NSRC(NSRC)) u_comb (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .pend_d_i(pend_d),
    .en_d_i  (en_d),
    .unm_d_i (unm_d),
    .pend_q_i(pend_q),
    .en_q_i  (en_q),
    .unm_q_i (unm_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    rsel = '0;
    case (rix)
      IX_W'(RIX_PEND):                        rsel[NSRC-1:0] = pend_q;
      IX_W'(RIX_EN_SET), IX_W'(RIX_EN_CLR):   rsel[NSRC-1:0] = en_q;
      IX_W'(RIX_UNM_SET), IX_W'(RIX_UNM_CLR): rsel[NSRC-1:0] = unm_q;
      default:                                rsel = '0;
    endcase
    rdata_d = rdata_q;
    if (bus_rd_i) rdata_d = rsel;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      if (bus_rd_i) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata_o = rdata_q;

  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !bus_rd_i |=> $stable(bus_rdata_o));

  // R8
  rdata_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_rd_i && rix == IX_W'(RIX_PEND)) |=> (bus_rdata_o[NSRC-1:0] == $past(pend_q)));

  // R2
  unused_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_wr_i && rix > IX_W'(RIX_UNM_CLR) && src_i == '0) |=>
      ($stable(en_q) && $stable(unm_q) && $stable(pend_q)));

endmodule

// File: tb/sim_irqmux_cascade.sv
module sim_irqmux_cascade;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  logic [15:0] m_pend, m_en, m_unm, m_rd;
  logic        m_irq;

  always #5 clk = ~clk;

  irqmux_cascade u0 (
    .clk_i      (clk),
    .arst_ni    (rst_n),
    .src_i      (src),
    .bus_rd_i   (rd),
    .bus_wr_i   (wr),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .irq_o      (irq)
  );

  // Behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_en = '0; m_unm = '0; m_rd = '0; m_irq = 1'b0;
    end else begin
      int ix;
      logic [15:0] np;
      ix = int'(addr[4:2]);
      if (rd) begin
        if (ix == 0) m_rd = m_pend;
        else if (ix == 1 || ix == 2) m_rd = m_en;
        else if (ix == 3 || ix == 4) m_rd = m_unm;
        else m_rd = '0;
      end
      for (int i = 0; i < 16; i++) begin
        if (src[i] && m_en[i]) np[i] = 1'b1;
        else if (wr && ix == 0 && wdata[i]) np[i] = 1'b0;
        else np[i] = m_pend[i];
      end
      if (wr && ix == 1) m_en = m_en | wdata;
      if (wr && ix == 2) m_en = m_en & ~wdata;
      if (wr && ix == 3) m_unm = m_unm | wdata;
      if (wr && ix == 4) m_unm = m_unm & ~wdata;
      m_pend = np;
      m_irq = |(m_pend & m_en & m_unm);
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Continuous comparison half a period after each edge
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R7 irq vs model", {15'd0, irq}, {15'd0, m_irq});
      check("R8 rdata vs model", rdata, m_rd);
    end
  end

  task automatic bus_wr(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, input string tag, input logic [15:0] exp);
    @(posedge clk); #2;
    rd = 1'b1; addr = a;
    @(posedge clk); #2;
    rd = 1'b0;
    check(tag, rdata, exp);
  endtask

  task automatic set_src(input logic [15:0] v);
    @(posedge clk); #2;
    src = v;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    #2;
    // R1 during reset
    check("R1 irq in reset", {15'd0, irq}, 16'h0);
    check("R1 rdata in reset", rdata, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    cmp_on = 1'b1;
    bus_rd(5'd0,  "R1 pending after reset", 16'h0000);
    bus_rd(5'd4,  "R1 enable after reset", 16'h0000);
    bus_rd(5'd12, "R1 unmask after reset", 16'h0000);

    // R9 start-up sequence
    bus_wr(5'd16, 16'hFFFF);
    bus_wr(5'd4,  16'hFFFF);
    bus_wr(5'd0,  16'hFFFF);
    check("R9 irq after init", {15'd0, irq}, 16'h0);
    bus_rd(5'd4,  "R9 enable after init", 16'hFFFF);
    bus_rd(5'd16, "R9 unmask after init", 16'h0000);
    bus_rd(5'd0,  "R9 pending after init", 16'h0000);

    // R5 latching while masked
    set_src(16'h0008);
    set_src(16'h0000);
    check("R5 masked source keeps irq low", {15'd0, irq}, 16'h0);
    bus_rd(5'd0, "R5 pending latched while masked", 16'h0008);

    // R4 / R7 unmask raises irq on the capture edge
    bus_wr(5'd12, 16'h0008);
    check("R7 irq after unmask", {15'd0, irq}, 16'h1);

    // R6 acknowledge
    bus_wr(5'd0, 16'h0000);
    check("R6 zero ack no effect", {15'd0, irq}, 16'h1);
    bus_wr(5'd0, 16'h0008);
    check("R6 ack clears irq", {15'd0, irq}, 16'h0);
    bus_rd(5'd0, "R6 pending after ack", 16'h0000);

    // R6 set wins over acknowledge
    set_src(16'h0020);
    bus_wr(5'd12, 16'h0020);
    check("R6 irq with held source", {15'd0, irq}, 16'h1);
    bus_wr(5'd0, 16'h0020);
    check("R6 held source survives ack", {15'd0, irq}, 16'h1);
    bus_rd(5'd0, "R6 pending survives ack", 16'h0020);
    set_src(16'h0000);
    bus_wr(5'd0, 16'h0020);
    check("R6 ack after source drops", {15'd0, irq}, 16'h0);

    // R3 enable clear / set zeros
    bus_wr(5'd8, 16'h0100);
    bus_rd(5'd4, "R3 enable after clear", 16'hFEFF);
    set_src(16'h0100);
    set_src(16'h0000);
    bus_rd(5'd0, "R5 disabled source ignored", 16'h0000);
    bus_wr(5'd4, 16'h0000);
    bus_rd(5'd8, "R3 zero set no effect", 16'hFEFF);

    // R2 low address bits ignored, unused indices
    bus_wr(5'd7, 16'h0100);
    bus_rd(5'd10, "R2 offset write reaches enable-set", 16'hFFFF);
    bus_wr(5'd24, 16'hFFFF);
    bus_rd(5'd13, "R2 unused write leaves unmask", 16'h0028);
    bus_rd(5'd20, "R2 index 5 reads zero", 16'h0000);
    bus_rd(5'd24, "R2 index 6 reads zero", 16'h0000);
    bus_rd(5'd28, "R2 index 7 reads zero", 16'h0000);

    // R4 mask clear
    bus_wr(5'd16, 16'h0008);
    bus_rd(5'd16, "R4 unmask after mask write", 16'h0020);

    // Pseudo-random traffic, compared to the model every cycle (R3 R4 R5 R6 R7 R8)
    lf = 32'h1234_5678;
    for (int k = 0; k < 600; k++) begin
      @(posedge clk); #2;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      src   = lf[15:0] & lf[31:16];
      addr  = lf[20:16];
      wdata = lf[31:16] ^ lf[15:0];
      rd = 1'b0; wr = 1'b0;
      case (lf[27:26])
        2'd0: wr = 1'b1;
        2'd1: rd = 1'b1;
        default: ;
      endcase
    end
    @(posedge clk); #2;
    rd = 1'b0; wr = 1'b0; src = '0;
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end

endmodule